// File: doc/BRIEF.md
# Show-Cycle External Bus Controller

This block sits between a microcontroller's internal system bus and its external bus pins. Each cycle it sees one internal bus access: address, function code, size, direction, data, and whether the target is an on-chip resource or an external one. From these it decides what the external pins show. A 2-bit show-cycle control field sets how accesses to on-chip resources appear outside the chip. In one setting the address, function code, size and direction lines still follow the access, but both strobes stay negated and the data bus floats. In another setting the data strobe marks the cycle and the internal data is driven out, so that a logic analyser can follow on-chip traffic.

The block also watches the bus-grant status. While an external master owns the bus, the strobes stay negated and the data pins are released. One encoding of the control field also raises a halt that stalls internal bus activity for as long as the grant lasts. For byte writes, the written byte is copied onto every byte lane of the data bus, so that narrow and wide devices both see it. The pins are registered: every output reflects the access presented one clock earlier. Arbitration and cycle termination belong to other logic.

Top module: `showcyc_ext_bus`

## Requirements
- R1: After reset the control field holds 00 (shows disabled), both strobes are negated (high), the data output enable is 0 and the halt output is 0.
- R2: A write strobe on the control port loads the 2-bit field. 00 = disabled, 01 = show enabled, 10 = reserved and treated as disabled, 11 = show enabled with internal halt during external mastership.
- R3: The address, function code, size and read/write outputs take the values of any accepted internal access one clock after it is presented, in every mode. Read/write is 1 for a read.
- R4: With shows disabled (00 or 10), an access to an on-chip target leaves the address strobe and data strobe negated and the data output enable at 0.
- R5: With shows enabled (01 or 11), an access to an on-chip target asserts the data strobe one clock later, leaves the address strobe negated, and drives the internal data word onto the external data bus.
- R6: The data output enable is registered. It returns to 0 in the first clock after the show cycle ends when no further access follows.
- R7: The halt output is 1 exactly while the field is 11 and the external bus is granted. In modes 00, 01 and 10 it stays 0 whatever the grant.
- R8: While the bus is granted, no presented access asserts either strobe or the data output enable.
- R9: An external byte write (size 01) asserts both strobes and drives the byte taken from bits [7:0] of the internal data onto both byte lanes ([15:8] and [7:0]).
- R10: An external word write (size 10) drives the internal data word unchanged with both strobes asserted. An external read asserts both strobes with the data output enable at 0.
- R11: The size output marks the valid portion of a show cycle: 10 = whole word, 01 = one byte. For an internal byte show at an even address the byte is valid on lane [15:8], and at an odd address on lane [7:0]. The other lane is indeterminate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Load strobe for the show-cycle control field |
| ctl_wdata | input | 2 | New control field value |
| ibus_valid | input | 1 | Internal access presented this cycle |
| ibus_on_chip | input | 1 | 1 when the access targets an on-chip resource |
| ibus_write | input | 1 | 1 for a write |
| ibus_size | input | 2 | Access size: 01 byte, 10 word, 00 long, 11 three-byte |
| ibus_addr | input | AW | Access address |
| ibus_fc | input | FCW | Function code |
| ibus_data | input | DW | Internal data word (write data or on-chip read data) |
| ext_grant | input | 1 | External bus granted to another master |
| ext_addr | output | AW | External address pins |
| ext_fc | output | FCW | External function code pins |
| ext_size | output | 2 | External size pins |
| ext_rw | output | 1 | External read/write (1 = read) |
| ext_as_n | output | 1 | Address strobe, active low |
| ext_ds_n | output | 1 | Data strobe, active low |
| ext_dout | output | DW | Data value presented to the pad drivers |
| ext_doe | output | 1 | Data pad output enable |
| ext_data | inout | DW | Tri-state external data bus |
| int_halt | output | 1 | Stall request for internal bus activity |

## Verification
Every cycle, the assertions check how the strobes relate to the previous cycle's access. The address strobe is only ever asserted for an external access and never without the data strobe. A disabled mode never drives the bus for an on-chip target. Byte writes always show identical lanes, and the halt never rises without a grant. Only the bench's scenarios can show the things that depend on chosen values: the reserved encoding acting as disabled, the exact data word that reaches the pins, which lane of an internal byte show is valid, and the release of the bus in the clock after a show.

// File: rtl/showcyc_pkg.sv
package showcyc_pkg;

  typedef enum logic [1:0] {
    SHOW_OFF      = 2'b00,
    SHOW_ON       = 2'b01,
    SHOW_RSVD     = 2'b10,
    SHOW_ON_HALT  = 2'b11
  } show_mode_e;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // Modes that mirror on-chip cycles onto the pins.
  function automatic logic f_show_on(input show_mode_e m);
    return (m == SHOW_ON) || (m == SHOW_ON_HALT);
  endfunction

  // Mode that stalls internal traffic during external mastership.
  function automatic logic f_halt_mode(input show_mode_e m);
    return (m == SHOW_ON_HALT);
  endfunction

  // A write whose size says a single byte is moving.
  function automatic logic f_is_byte_write(input logic wr, input logic [1:0] sz);
    return wr && (sz == SZ_BYTE);
  endfunction

endpackage

// File: rtl/showcyc_mode_reg.sv
module showcyc_mode_reg
  import showcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  input  logic       ext_grant,
  output show_mode_e mode,
  output logic       show_on,
  output logic       int_halt
);

  show_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= SHOW_OFF;
    else if (ctl_we) mode_q <= show_mode_e'(ctl_wdata);
  end

  assign mode     = mode_q;
  assign show_on  = f_show_on(mode_q);
  assign int_halt = f_halt_mode(mode_q) && ext_grant;

  // R7: a halt only exists while another master holds the bus
  assert_halt_needs_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_halt |-> ext_grant);

endmodule

// File: rtl/showcyc_data_mux.sv
module showcyc_data_mux
  import showcyc_pkg::*;
#(
  parameter int DW = 16,
  localparam int NLANES = DW / 8
) (
  input  logic          is_write,
  input  logic [1:0]    size,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out
);

  logic byte_wr;
  assign byte_wr = f_is_byte_write(is_write, size);

  // Copy the low byte onto every lane for byte writes, else pass the word.
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign data_out[g*8 +: 8] = byte_wr ? data_in[7:0] : data_in[g*8 +: 8];
  end

endmodule

// File: rtl/showcyc_pin_stage.sv
module showcyc_pin_stage
  import showcyc_pkg::*;
#(
  parameter int AW  = 24,
  parameter int FCW = 3,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic           ext_evt,
  input  logic           show_evt,
  input  logic           acc_write,
  input  logic [1:0]     acc_size,
  input  logic [AW-1:0]  acc_addr,
  input  logic [FCW-1:0] acc_fc,
  input  logic [DW-1:0]  acc_word,
  output logic [AW-1:0]  ext_addr,
  output logic [FCW-1:0] ext_fc,
  output logic [1:0]     ext_size,
  output logic           ext_rw,
  output logic           ext_as_n,
  output logic           ext_ds_n,
  output logic [DW-1:0]  ext_dout,
  output logic           ext_doe
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_addr <= '0;
      ext_fc   <= '0;
      ext_size <= SZ_WORD;
      ext_rw   <= 1'b1;
      ext_as_n <= 1'b1;
      ext_ds_n <= 1'b1;
      ext_dout <= '0;
      ext_doe  <= 1'b0;
    end else begin
      if (acc_valid) begin
        ext_addr <= acc_addr;
        ext_fc   <= acc_fc;
        ext_size <= acc_size;
        ext_rw   <= !acc_write;
        ext_dout <= acc_word;
      end
      ext_as_n <= !ext_evt;
      ext_ds_n <= !(ext_evt || show_evt);
      ext_doe  <= (ext_evt && acc_write) || show_evt;
    end
  end

endmodule

// File: rtl/showcyc_ext_bus.sv
module showcyc_ext_bus
  import showcyc_pkg::*;
#(
  parameter int AW  = 24,
  parameter int FCW = 3,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [1:0]     ctl_wdata,
  input  logic           ibus_valid,
  input  logic           ibus_on_chip,
  input  logic           ibus_write,
  input  logic [1:0]     ibus_size,
  input  logic [AW-1:0]  ibus_addr,
  input  logic [FCW-1:0] ibus_fc,
  input  logic [DW-1:0]  ibus_data,
  input  logic           ext_grant,
  output logic [AW-1:0]  ext_addr,
  output logic [FCW-1:0] ext_fc,
  output logic [1:0]     ext_size,
  output logic           ext_rw,
  output logic           ext_as_n,
  output logic           ext_ds_n,
  output logic [DW-1:0]  ext_dout,
  output logic           ext_doe,
  inout  wire  [DW-1:0]  ext_data,
  output logic           int_halt
);

  show_mode_e    mode;
  logic          show_on;
  logic          own_bus;
  logic          ext_evt;
  logic          show_evt;
  logic [DW-1:0] bus_word;

  showcyc_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ext_grant (ext_grant),
    .mode      (mode),
    .show_on   (show_on),
    .int_halt  (int_halt)
  );

  // Named events: pins belong to this block only without a grant.
  assign own_bus  = ibus_valid && !ext_grant;
  assign ext_evt  = own_bus && !ibus_on_chip;
  assign show_evt = own_bus && ibus_on_chip && show_on;

  showcyc_data_mux #(.DW(DW)) u_mux (
    .is_write (ibus_write),
    .size     (ibus_size),
    .data_in  (ibus_data),
    .data_out (bus_word)
  );

  showcyc_pin_stage #(.AW(AW), .FCW(FCW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (ibus_valid),
    .ext_evt   (ext_evt),
    .show_evt  (show_evt),
    .acc_write (ibus_write),
    .acc_size  (ibus_size),
    .acc_addr  (ibus_addr),
    .acc_fc    (ibus_fc),
    .acc_word  (bus_word),
    .ext_addr  (ext_addr),
    .ext_fc    (ext_fc),
    .ext_size  (ext_size),
    .ext_rw    (ext_rw),
    .ext_as_n  (ext_as_n),
    .ext_ds_n  (ext_ds_n),
    .ext_dout  (ext_dout),
    .ext_doe   (ext_doe)
  );

  assign ext_data = ext_doe ? ext_dout : {DW{1'bz}};

  // R4/R10: address strobe only follows an external access, never a show
  assert_as_only_external_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ibus_valid && ibus_on_chip) |-> ext_as_n);

  // R10: address strobe never appears without data strobe
  assert_as_implies_ds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_as_n |-> !ext_ds_n);

  // R4: disabled modes never drive the bus for an on-chip target
  assert_hidden_floats_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_valid && ibus_on_chip && !show_on) |=> !ext_doe);

  // R5: a show event yields data strobe and drive in the next cycle
  assert_show_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    show_evt |=> (!ext_ds_n && ext_doe && ext_as_n));

  // R8: a granted bus carries no strobe from this block
  assert_grant_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_grant |=> (ext_as_n && ext_ds_n && !ext_doe));

  // R9: driven byte writes have identical lanes
  assert_byte_replicated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_doe && !ext_rw && ext_size == SZ_BYTE) |-> (ext_dout[15:8] == ext_dout[7:0]));

endmodule

// File: tb/sim_showcyc_ext_bus.sv
module sim_showcyc_ext_bus;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [1:0]  ctl_wdata;
  logic        ibus_valid, ibus_on_chip, ibus_write;
  logic [1:0]  ibus_size;
  logic [23:0] ibus_addr;
  logic [2:0]  ibus_fc;
  logic [15:0] ibus_data;
  logic        ext_grant;
  logic [23:0] ext_addr;
  logic [2:0]  ext_fc;
  logic [1:0]  ext_size;
  logic        ext_rw, ext_as_n, ext_ds_n, ext_doe, int_halt;
  logic [15:0] ext_dout;
  wire  [15:0] ext_data;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  showcyc_ext_bus u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ibus_valid(ibus_valid), .ibus_on_chip(ibus_on_chip), .ibus_write(ibus_write),
    .ibus_size(ibus_size), .ibus_addr(ibus_addr), .ibus_fc(ibus_fc),
    .ibus_data(ibus_data), .ext_grant(ext_grant), .ext_addr(ext_addr),
    .ext_fc(ext_fc), .ext_size(ext_size), .ext_rw(ext_rw), .ext_as_n(ext_as_n),
    .ext_ds_n(ext_ds_n), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_data(ext_data), .int_halt(int_halt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = m;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // Present one access for one cycle; returns at the negedge after capture.
  task automatic access(input logic on_chip, input logic wr, input logic [1:0] sz,
                        input logic [23:0] a, input logic [2:0] fc, input logic [15:0] d);
    @(negedge clk);
    ibus_valid = 1'b1; ibus_on_chip = on_chip; ibus_write = wr;
    ibus_size = sz; ibus_addr = a; ibus_fc = fc; ibus_data = d;
    @(negedge clk);
    ibus_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mode-hidden ds", {31'd0, ext_ds_n}, 32'd1);
    check("R1 as", {31'd0, ext_as_n}, 32'd1);
    check("R1 doe", {31'd0, ext_doe}, 32'd0);
    check("R1 halt", {31'd0, int_halt}, 32'd0);
    access(1'b1, 1'b0, 2'b10, 24'h000100, 3'd5, 16'h1234);
    check("R1 reset mode is disabled: ds", {31'd0, ext_ds_n}, 32'd1);
  endtask

  task automatic t_disabled(input logic [1:0] m, input string tag);
    set_mode(m);
    access(1'b1, 1'b1, 2'b10, 24'hABCDE2, 3'd6, 16'hBEEF);
    check({tag, " addr"}, {8'd0, ext_addr}, 32'h00ABCDE2);
    check({tag, " fc"}, {29'd0, ext_fc}, 32'd6);
    check({tag, " size"}, {30'd0, ext_size}, 32'd2);
    check({tag, " rw"}, {31'd0, ext_rw}, 32'd0);
    check({tag, " as"}, {31'd0, ext_as_n}, 32'd1);
    check({tag, " ds"}, {31'd0, ext_ds_n}, 32'd1);
    check({tag, " doe"}, {31'd0, ext_doe}, 32'd0);
  endtask

  task automatic t_show(input logic [1:0] m);
    set_mode(m);
    access(1'b1, 1'b0, 2'b10, 24'h000400, 3'd5, 16'hC0DE);
    check("R5 ds asserted", {31'd0, ext_ds_n}, 32'd0);
    check("R5 as negated", {31'd0, ext_as_n}, 32'd1);
    check("R5 doe", {31'd0, ext_doe}, 32'd1);
    check("R5 data on bus", {16'd0, ext_data}, 32'h0000C0DE);
    check("R3 rw read", {31'd0, ext_rw}, 32'd1);
    @(negedge clk);
    check("R6 doe released", {31'd0, ext_doe}, 32'd0);
    check("R6 ds released", {31'd0, ext_ds_n}, 32'd1);
  endtask

  task automatic t_halt;
    set_mode(2'b01);
    ext_grant = 1'b1; #1;
    check("R7 no halt in 01", {31'd0, int_halt}, 32'd0);
    ext_grant = 1'b0;
    set_mode(2'b11);
    check("R7 no halt without grant", {31'd0, int_halt}, 32'd0);
    ext_grant = 1'b1; #1;
    check("R7 halt in 11 with grant", {31'd0, int_halt}, 32'd1);
    ext_grant = 1'b0; #1;
    check("R7 halt drops with grant", {31'd0, int_halt}, 32'd0);
    set_mode(2'b00);
    ext_grant = 1'b1; #1;
    check("R7 no halt in 00", {31'd0, int_halt}, 32'd0);
    ext_grant = 1'b0;
  endtask

  task automatic t_grant;
    set_mode(2'b01);
    ext_grant = 1'b1;
    access(1'b1, 1'b1, 2'b10, 24'h000010, 3'd5, 16'h5555);
    check("R8 show suppressed ds", {31'd0, ext_ds_n}, 32'd1);
    check("R8 show suppressed doe", {31'd0, ext_doe}, 32'd0);
    access(1'b0, 1'b1, 2'b10, 24'h800010, 3'd1, 16'h6666);
    check("R8 external suppressed as", {31'd0, ext_as_n}, 32'd1);
    ext_grant = 1'b0;
  endtask

  task automatic t_ext;
    set_mode(2'b00);
    access(1'b0, 1'b1, 2'b01, 24'h800001, 3'd1, 16'h12A5);
    check("R9 as", {31'd0, ext_as_n}, 32'd0);
    check("R9 ds", {31'd0, ext_ds_n}, 32'd0);
    check("R9 both lanes", {16'd0, ext_data}, 32'h0000A5A5);
    access(1'b0, 1'b1, 2'b10, 24'h800002, 3'd1, 16'h3C96);
    check("R10 word write", {16'd0, ext_data}, 32'h00003C96);
    access(1'b0, 1'b0, 2'b10, 24'h800004, 3'd1, 16'h0000);
    check("R10 read as", {31'd0, ext_as_n}, 32'd0);
    check("R10 read doe", {31'd0, ext_doe}, 32'd0);
  endtask

  task automatic t_byte_show;
    set_mode(2'b01);
    access(1'b1, 1'b1, 2'b01, 24'h000020, 3'd5, 16'h0077);
    check("R11 size byte", {30'd0, ext_size}, 32'd1);
    check("R11 even lane upper", {24'd0, ext_data[15:8]}, 32'h77);
    access(1'b1, 1'b1, 2'b01, 24'h000021, 3'd5, 16'h0088);
    check("R11 odd lane lower", {24'd0, ext_data[7:0]}, 32'h88);
  endtask

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = 2'b00;
    ibus_valid = 1'b0; ibus_on_chip = 1'b0; ibus_write = 1'b0;
    ibus_size = 2'b10; ibus_addr = '0; ibus_fc = '0; ibus_data = '0;
    ext_grant = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled(2'b00, "R3/R4 mode00");
    t_disabled(2'b10, "R2 reserved acts disabled");
    t_show(2'b01);
    t_show(2'b11);
    t_halt();
    t_grant();
    t_ext();
    t_byte_show();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule